// File: doc/BRIEF.md
# Five-lane 7:1 serial deserializer

The block turns five serial data lanes into one 35-bit parallel word per frame. A forwarded frame clock marks the frame boundaries. A bit-rate clock runs at seven times the frame rate, is phase-aligned to the frame, and drives every register. The block samples each lane once per bit clock. It finds slot 0 from the low-to-high transition of the sampled frame clock and collects seven slots per lane. It undoes the rotated bit order used on the wire and captures the whole frame in a holding register. A regenerated output clock runs at the frame rate.

A select pin chooses which edge of the output clock the receiving logic captures on. The block launches data on the opposite edge. The frame period can range from 8.93 ns to 125 ns. The regenerated output clock always has the same period as the input frame clock.

Two control pins set the output state:
- With output enable low, the outputs float.
- With power-down active, the outputs are driven low and the internal state is cleared.

After a wake-up, a frame counter stands in for the clock generator's settling time, which can be up to about 10 ms on a real device. Until the counter expires, the outputs stay low. When it expires, a lock indication asserts.

Top module: `serial7_lane_rx`

## Requirements
- R1: Bit b of lane l appears on `word_out[7*l + b]`, for the five lanes l = 0..4 and the seven bits b = 0..6.
- R2: Within one frame, slot 0 is the first bit after the frame boundary. The slots carry bits in the time order 1, 0, 6, 5, 4, 3, 2.
- R3: Slot 0 is the lane sample taken on the first `bit_clk` rising edge at which `frame_clk` reads high after a read of low. A wake-up that finds `frame_clk` already high does not start a frame. No frame is captured before the first such transition.
- R4: Each captured frame is launched once per frame.
  - With `rise_sel` = 1, `word_out` changes only together with a falling edge of `clk_out`, 12 bit clocks after the slot-0 sample edge.
  - With `rise_sel` = 0, `word_out` changes only together with a rising edge of `clk_out`, 8 bit clocks after the slot-0 sample edge.
- R5: While locked, `clk_out` has a period of 7 bit clocks: high for 4 cycles and low for 3. It rises on the bit-clock edge that follows the slot-0 sample edge.
- R6: With `out_en` low, all 35 data outputs and `clk_out` are high impedance, whatever the other inputs are.
- R7: With `out_en` high and `awake` low, data and `clk_out` are driven 0 and `locked` is 0. Power-down synchronously clears sampling, alignment, capture and the settle count.
- R8: After a wake-up, `locked`, data and `clk_out` stay 0 until SETTLE_FRAMES frame starts have been seen. `locked` then rises and stays high until the next power-down.
- R9: `rsvd` must be low for normal operation. While it is high, the block behaves exactly as in power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit-rate clock, seven times the frame rate, phase-aligned |
| frame_clk | input | 1 | Forwarded frame clock; high for slots 0-3 |
| lane_in | input | 5 | Serial data, one bit per lane per bit clock |
| awake | input | 1 | Low = power-down (synchronous clear, outputs low) |
| out_en | input | 1 | Low = all outputs high impedance |
| rise_sel | input | 1 | 1: receiver captures on the rising edge of `clk_out`; 0: on the falling edge |
| rsvd | input | 1 | Reserved, hold low |
| word_out | output | 35 | Recovered frame, five 7-bit lane words |
| clk_out | output | 1 | Regenerated frame-rate clock |
| locked | output | 1 | Settle period elapsed, data valid |

## Verification
The bench drives random words through the rotated slot order. If the reorder were mapped wrongly, bits would swap within a lane word, so the R1 and R2 checks would catch it. The bench also wakes the block in mid-frame while the frame clock is high. An edge detector that woke up believing the previous level was low would take a false slot 0 there, and every following word would be rotated. Each output-edge mode is checked on every change of `word_out`, so launching on the wrong edge or a cycle late is caught. The bench also covers the combinations where power-down and output enable overlap, and the reserved pin alone. In those runs, a design that ranked the controls in the wrong order would drive zeros where high impedance is expected, or the other way round.

// File: rtl/serial7_lane_rx.sv
`timescale 1ns/1ps
module serial7_lane_rx #(
  parameter int LANES = 5,
  parameter int BITS = 7,
  parameter int LEAD = 1,
  parameter int SETTLE_FRAMES = 1024
) (
  input  logic                  bit_clk,
  input  logic                  frame_clk,
  input  logic [LANES-1:0]      lane_in,
  input  logic                  awake,
  input  logic                  out_en,
  input  logic                  rise_sel,
  input  logic                  rsvd,
  output logic [LANES*BITS-1:0] word_out,
  output logic                  clk_out,
  output logic                  locked
);
  localparam int W  = LANES * BITS;
  localparam int PW = $clog2(BITS);
  localparam int HI = (BITS + 1) / 2;
  localparam int CW = $clog2(SETTLE_FRAMES + 1);

  logic                          run;
  logic [LANES-1:0]              ln_q;
  logic                          fr_q, fr_d;
  logic [LANES-1:0][BITS-2:0]    sh;
  logic [LANES-1:0][BITS-1:0]    vv;
  logic [PW-1:0]                 ph_r, cur_ph;
  logic                          start, seen;
  logic [W-1:0]                  frame_w, cap, dout, data_drv;
  logic                          ck_r, lock_r, ck_drv;
  logic [CW-1:0]                 cnt;

  assign run    = awake & ~rsvd;
  assign start  = fr_q & ~fr_d;
  assign cur_ph = start ? '0 : ph_r;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign vv[l] = {sh[l], ln_q[l]};
    for (genvar b = 0; b < BITS; b++) begin : g_bit
      localparam int S = (LEAD + BITS - b) % BITS;
      assign frame_w[l*BITS + b] = vv[l][BITS-1-S];
    end
  end

  always_ff @(posedge bit_clk) begin
    if (!run) begin
      ln_q   <= '0;
      fr_q   <= 1'b1;
      fr_d   <= 1'b1;
      sh     <= '0;
      ph_r   <= '0;
      seen   <= 1'b0;
      cap    <= '0;
      dout   <= '0;
      ck_r   <= 1'b0;
      lock_r <= 1'b0;
      cnt    <= '0;
    end else begin
      ln_q <= lane_in;
      fr_q <= frame_clk;
      fr_d <= fr_q;
      for (int l = 0; l < LANES; l++) sh[l] <= {sh[l][BITS-3:0], ln_q[l]};
      ph_r <= (cur_ph == PW'(BITS-1)) ? '0 : cur_ph + 1'b1;
      if (start) seen <= 1'b1;
      if (seen && cur_ph == PW'(BITS-1)) cap <= frame_w;
      ck_r <= cur_ph < PW'(HI);
      if ((!rise_sel && cur_ph == '0) || (rise_sel && cur_ph == PW'(HI))) dout <= cap;
      if (start && !lock_r) begin
        if (cnt == CW'(SETTLE_FRAMES-1)) lock_r <= 1'b1;
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign data_drv = (run && lock_r) ? dout : '0;
  assign ck_drv   = run & lock_r & ck_r;
  assign word_out = out_en ? data_drv : {W{1'bz}};
  assign clk_out  = out_en ? ck_drv : 1'bz;
  assign locked   = run & lock_r;
endmodule

// File: rtl/serial7_lane_rx_chk.sv
`timescale 1ns/1ps
module serial7_lane_rx_chk #(
  parameter int W = 35
) (
  input logic         bit_clk,
  input logic         run,
  input logic         rise_sel,
  input logic         rsvd,
  input logic         start,
  input logic         seen,
  input logic         lock_r,
  input logic         ck_r,
  input logic [W-1:0] cap,
  input logic [W-1:0] dout
);
  // R7
  pd_clear_chk: assert property (@(posedge bit_clk)
    !run |=> (!lock_r && cap == '0 && dout == '0));

  // R9
  rsvd_hold_chk: assert property (@(posedge bit_clk)
    rsvd |=> !lock_r);

  // R8
  lock_keep_chk: assert property (@(posedge bit_clk) disable iff (!run)
    lock_r |=> lock_r);

  // R8
  lock_on_frame_chk: assert property (@(posedge bit_clk) disable iff (!run)
    $rose(lock_r) |-> $past(start));

  // R4
  launch_fall_chk: assert property (@(posedge bit_clk) disable iff (!run)
    ($past(run) && !$stable(dout) && $past(rise_sel)) |-> (!ck_r && $past(ck_r)));

  // R4
  launch_rise_chk: assert property (@(posedge bit_clk) disable iff (!run)
    ($past(run) && !$stable(dout) && !$past(rise_sel)) |-> (ck_r && !$past(ck_r)));

  // R5
  ck_after_start_chk: assert property (@(posedge bit_clk) disable iff (!run)
    (start && seen) |=> ck_r);

  // R3
  capture_aligned_chk: assert property (@(posedge bit_clk) disable iff (!run)
    ($past(run) && !$stable(cap)) |-> $past(seen));
endmodule

bind serial7_lane_rx serial7_lane_rx_chk #(.W(W)) u_chk (
  .bit_clk(bit_clk), .run(run), .rise_sel(rise_sel), .rsvd(rsvd),
  .start(start), .seen(seen), .lock_r(lock_r), .ck_r(ck_r),
  .cap(cap), .dout(dout)
);

// File: tb/sim_serial7_lane_rx.sv
`timescale 1ns/1ps
module sim_serial7_lane_rx;
  localparam int LANES = 5;
  localparam int BITS = 7;
  localparam int SETTLE = 4;
  localparam int W = LANES * BITS;

  logic bit_clk = 1'b0;
  always #10 bit_clk = ~bit_clk;

  logic             frame_clk = 1'b0;
  logic [LANES-1:0] lane_in = '0;
  logic             awake = 1'b0, out_en = 1'b1, rise_sel = 1'b1, rsvd = 1'b0;
  wire  [W-1:0]     word_out;
  wire              clk_out;
  wire              locked;

  serial7_lane_rx #(.LANES(LANES), .BITS(BITS), .LEAD(1), .SETTLE_FRAMES(SETTLE)) u0 (
    .bit_clk(bit_clk), .frame_clk(frame_clk), .lane_in(lane_in), .awake(awake),
    .out_en(out_en), .rise_sel(rise_sel), .rsvd(rsvd),
    .word_out(word_out), .clk_out(clk_out), .locked(locked)
  );

  int checks = 0, failures = 0;
  bit done = 1'b0;
  int drv_slot = 3;
  logic [W-1:0] drv_word = '0;

  bit m_first = 1, m_aligned = 0, m_cur_start = 0, m_locked = 0, m_ck = 0;
  int m_cur = 0, m_cnt = 0;
  logic [W-1:0] m_cur_word = '0, m_cap = '0, m_dout = '0;

  always @(posedge bit_clk) begin
    if (!(awake && !rsvd)) begin
      m_first = 1; m_aligned = 0; m_cur_start = 0; m_locked = 0; m_ck = 0;
      m_cur = 0; m_cnt = 0; m_cap = '0; m_dout = '0;
    end else begin
      if (m_aligned) begin
        if (m_cur == 6) m_cap = m_cur_word;
        if (!rise_sel && m_cur == 0) m_dout = m_cap;
        if (rise_sel && m_cur == 4) m_dout = m_cap;
        m_ck = (m_cur < 4);
      end
      if (m_cur_start && !m_locked) begin
        m_cnt++;
        if (m_cnt == SETTLE) m_locked = 1;
      end
      m_cur_start = (drv_slot == 0) && !m_first;
      if (m_cur_start) m_aligned = 1;
      m_first = 0;
      m_cur = drv_slot;
      m_cur_word = drv_word;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input string act, input string exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%s expected=%s", req, what, act, exp);
    end
  endtask

  logic [W-1:0] prev_w;
  logic prev_c;
  bit prev_ok = 0;

  task automatic compare();
    logic [W-1:0] ew;
    logic ec, el;
    string tw, tc, tl;
    bit run, live;
    run = awake && !rsvd;
    live = out_en && run && m_locked;
    el = run && m_locked;
    tl = !run ? (rsvd ? "R9" : "R7") : "R8";
    if (!out_en) begin
      ew = {W{1'bz}}; ec = 1'bz; tw = "R6"; tc = "R6";
    end else if (!run) begin
      ew = '0; ec = 1'b0; tw = rsvd ? "R9" : "R7"; tc = tw;
    end else if (!m_locked) begin
      ew = '0; ec = 1'b0; tw = "R8"; tc = "R8";
    end else begin
      ew = m_dout; ec = m_ck; tw = "R1 R2 R3"; tc = "R5";
    end
    chk(word_out === ew, tw, "word_out", $sformatf("%h", word_out), $sformatf("%h", ew));
    chk(clk_out === ec, tc, "clk_out", $sformatf("%b", clk_out), $sformatf("%b", ec));
    chk(locked === el, tl, "locked", $sformatf("%b", locked), $sformatf("%b", el));
    if (live && prev_ok && word_out !== prev_w) begin
      if (rise_sel)
        chk(prev_c === 1'b1 && clk_out === 1'b0, "R4", "launch on falling clk_out",
            $sformatf("%b->%b", prev_c, clk_out), "1->0");
      else
        chk(prev_c === 1'b0 && clk_out === 1'b1, "R4", "launch on rising clk_out",
            $sformatf("%b->%b", prev_c, clk_out), "0->1");
    end
    prev_ok = live;
    prev_w = word_out;
    prev_c = clk_out;
  endtask

  task automatic drive();
    drv_slot = (drv_slot + 1) % BITS;
    if (drv_slot == 0) drv_word = W'({$urandom(), $urandom()});
    frame_clk = (drv_slot < 4);
    for (int l = 0; l < LANES; l++)
      lane_in[l] = drv_word[l*BITS + (BITS + 1 - drv_slot) % BITS];
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge bit_clk);
      compare();
      drive();
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    drv_word = W'({$urandom(), $urandom()});
    // R7: power-down state with outputs enabled
    step(20);
    // R8, R4 rise_sel=1: wake and settle
    awake = 1'b1;
    step(7 * 20);
    // R4, R5 rise_sel=0
    rise_sel = 1'b0;
    step(7 * 20);
    // R6: outputs floated
    out_en = 1'b0;
    step(7 * 5);
    out_en = 1'b1;
    step(7 * 5);
    // R7, R3: power-down and wake mid-frame
    step(3);
    awake = 1'b0;
    step(10);
    awake = 1'b1;
    step(7 * 15);
    // R9: reserved pin high
    rsvd = 1'b1;
    step(7 * 3);
    rsvd = 1'b0;
    step(7 * 15);
    // R6 over R7: float wins over power-down
    rise_sel = 1'b1;
    awake = 1'b0;
    out_en = 1'b0;
    step(14);
    out_en = 1'b1;
    step(7);
    awake = 1'b1;
    step(7 * 12);
    summary();
    $finish;
  end
endmodule